// File: doc/BRIEF.md
# Serial Voltage-ID Write Receiver

This block is a write-only target on a shared two-wire serial bus (I2C-style, SCL and SDA, open-drain). It accepts voltage-ID commands for a controller that regulates two outputs. Two strap pins set part of the bus address, so up to four such controllers can share one bus. Two command addresses exist. The first sets the output-1 code and puts output 2 back into tracking mode, where output 2 follows half of output 1. The second sets a separate margin code for output 2 only. In each data byte the top bit is a power-save request. The block drops that bit, and the low seven bits form the code.

SCL and SDA are oversampled on the system clock through a synchroniser. A byte engine frames start and stop conditions, shifts in bits and drives the acknowledge. A register stage holds the active codes. Before the first rising edge of `enable`, a serial write may already have set the codes. If none has, that edge loads a boot code for output 1, chosen by two pins from a parameter table, and output 2 tracks.

The byte engine has these states:
- `S_IDLE`
- `S_ADDR` (shifting the address byte)
- `S_ADDR_ACK`
- `S_DATA` (shifting a data byte)
- `S_DATA_ACK`
- `S_SKIP` (ignoring the transfer until the next start or stop)

Its transitions are:
- A start moves any state to `S_ADDR`.
- A stop moves any state to `S_IDLE`.
- After eight bits, `S_ADDR` goes to `S_ADDR_ACK` on a matching write address and to `S_SKIP` otherwise.
- After eight bits, `S_DATA` goes to `S_DATA_ACK`.
- Each acknowledge state returns to `S_DATA` on the falling edge of the ninth clock.

Top module: `svid_rx`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Data bits are sampled on the SCL rising edge, most significant bit first, eight bits to a byte.
- R2: An address byte b is accepted only when all of these hold: b[7:5] = 110, b[4] = strap[1], b[3] = strap[0] and b[0] = 0 (write). b[2:1] = 10 selects the "both outputs" command (0xDC with both straps high) and b[2:1] = 01 selects the "output 2 only" command (0xDA with both straps high). Any other address byte is ignored and changes nothing.
- R3: The block pulls SDA low during the ninth clock, from the falling edge of the eighth clock to the falling edge of the ninth. It does so after an accepted address byte and after every data byte that follows one. It never pulls SDA for a read request (b[0] = 1) or a non-matching address, nor for the data bytes that follow either.
- R4: Bit 7 of a data byte is the power-save flag and is discarded. The code is bits 6:0.
- R5: A "both outputs" transfer ending in a stop sets `vout1_code` to the code and sets `track_mode` to 1.
- R6: An "output 2 only" transfer ending in a stop sets `vout2_code` to the code, sets `track_mode` to 0 and leaves `vout1_code` unchanged.
- R7: A register update happens only on a stop that follows at least one complete, acknowledged data byte, and the last such byte is used. A transfer cut by a repeated start, or one that carries only an address, changes nothing.
- R8: On the first rising edge of `enable` after reset, if no update has happened yet, `vout1_code` takes the boot code picked by `boot_sel` and `track_mode` becomes 1. With the default parameter, the boot codes for `boot_sel` 0, 1, 2 and 3 are 0x30, 0x28, 0x20 and 0x18. Later edges of `enable` have no effect.
- R9: A serial update before the first `enable` rising edge takes priority over the boot code, so that edge leaves the codes unchanged.
- R10: After reset, `vout1_code` = 0, `vout2_code` = 0, `track_mode` = 1 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level (wired-AND bus) |
| sda_pull | output | 1 | 1 = drive SDA low (acknowledge) |
| strap | input | 2 | Controller identity, compared with address bits 4:3 |
| boot_sel | input | 2 | Boot code selector |
| enable | input | 1 | Controller enable, synchronous to clk |
| vout1_code | output | 7 | Active output-1 code |
| vout2_code | output | 7 | Output-2 margin code |
| track_mode | output | 1 | 1 = output 2 tracks half of output 1, 0 = margin code in use |

## Verification
The assertions assume the following about the inputs:
- SDA changes while SCL is high only to form a start or a stop.
- Each SCL level lasts longer than the synchroniser delay, so every edge is seen exactly once.
- `strap` is static during a transfer.

The bench drives every SCL and SDA change from the bus-master tasks with ten system clocks between changes, and it changes `strap` only while the bus is idle. Its random mix (address kinds, data values, byte counts, aborted frames) therefore keeps within those assumptions.

// File: rtl/svid_pkg.sv
package svid_pkg;
    localparam int CODE_W  = 7;
    localparam int BYTE_W  = 8;
    localparam logic [2:0] ADDR_HI = 3'b110;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_BOTH = 2'd1,
        CMD_OUT2 = 2'd2
    } cmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_DATA,
        S_DATA_ACK,
        S_SKIP
    } rx_state_e;

    // Decode an address byte against the strap identity; write only.
    function automatic cmd_e addr_decode(input logic [BYTE_W-1:0] b,
                                         input logic [1:0] id);
        cmd_e r;
        r = CMD_NONE;
        if (b[7:5] == ADDR_HI && b[4:3] == id && b[0] == 1'b0) begin
            unique case (b[2:1])
                2'b10:   r = CMD_BOTH;
                2'b01:   r = CMD_OUT2;
                default: r = CMD_NONE;
            endcase
        end
        return r;
    endfunction
endpackage

// File: rtl/svid_sync.sv
module svid_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic scl_q, sda_q;
    logic scl_s;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[STAGES-2:0], sda_in};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    assign scl_s     = scl_sh[STAGES-1];
    assign sda_s     = sda_sh[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/svid_byte_fsm.sv
module svid_byte_fsm
    import svid_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [1:0]        strap,
    output logic              sda_pull,
    output logic              commit,
    output cmd_e              cmd,
    output logic [CODE_W-1:0] code
);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

    rx_state_e         state, state_n;
    logic [3:0]        cnt, cnt_n;
    logic [BYTE_W-1:0] shreg, shreg_n;
    cmd_e              cmd_q, cmd_n;
    logic [CODE_W-1:0] pend, pend_n;
    logic              have, have_n;
    cmd_e              dec;

    assign dec = addr_decode(shreg, strap);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
            shreg <= '0;
            cmd_q <= CMD_NONE;
            pend  <= '0;
            have  <= 1'b0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            shreg <= shreg_n;
            cmd_q <= cmd_n;
            pend  <= pend_n;
            have  <= have_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        shreg_n = shreg;
        cmd_n   = cmd_q;
        pend_n  = pend;
        have_n  = have;
        if (start_det) begin
            state_n = S_ADDR;
            cnt_n   = '0;
            have_n  = 1'b0;
            cmd_n   = CMD_NONE;
        end else if (stop_det) begin
            state_n = S_IDLE;
            have_n  = 1'b0;
        end else begin
            unique case (state)
                S_IDLE, S_SKIP: begin
                end
                S_ADDR, S_DATA: begin
                    if (scl_rise && cnt < LAST_BIT) begin
                        shreg_n = {shreg[BYTE_W-2:0], sda_s};
                        cnt_n   = cnt + 4'd1;
                    end else if (scl_fall && cnt == LAST_BIT) begin
                        if (state == S_ADDR) begin
                            if (dec != CMD_NONE) begin
                                cmd_n   = dec;
                                state_n = S_ADDR_ACK;
                            end else begin
                                state_n = S_SKIP;
                            end
                        end else begin
                            pend_n  = shreg[CODE_W-1:0];
                            state_n = S_DATA_ACK;
                        end
                    end
                end
                S_ADDR_ACK, S_DATA_ACK: begin
                    if (scl_fall) begin
                        state_n = S_DATA;
                        cnt_n   = '0;
                        if (state == S_DATA_ACK) have_n = 1'b1;
                    end
                end
                default: state_n = S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_pull = (state == S_ADDR_ACK) || (state == S_DATA_ACK);
        commit   = stop_det && !start_det && have;
        cmd      = cmd_q;
        code     = pend;
    end

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST_BIT);
    p_start_to_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> state == S_ADDR);
    p_ack_after_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> cnt == LAST_BIT);
    p_commit_has_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> cmd_q != CMD_NONE);
endmodule

// File: rtl/svid_regs.sv
module svid_regs
    import svid_pkg::*;
#(
    parameter logic [4*CODE_W-1:0] BOOT_CODES = {7'h18, 7'h20, 7'h28, 7'h30}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  cmd_e              cmd,
    input  logic [CODE_W-1:0] code,
    input  logic              enable,
    input  logic [1:0]        boot_sel,
    output logic [CODE_W-1:0] vout1_code,
    output logic [CODE_W-1:0] vout2_code,
    output logic              track_mode
);
    logic en_q, written, booted;
    logic en_rise, boot_load;

    assign en_rise   = enable & ~en_q;
    assign boot_load = en_rise & ~booted & ~written & ~commit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            written    <= 1'b0;
            booted     <= 1'b0;
            vout1_code <= '0;
            vout2_code <= '0;
            track_mode <= 1'b1;
        end else begin
            en_q <= enable;
            if (en_rise) booted <= 1'b1;
            if (commit) begin
                written <= 1'b1;
                if (cmd == CMD_BOTH) begin
                    vout1_code <= code;
                    track_mode <= 1'b1;
                end else if (cmd == CMD_OUT2) begin
                    vout2_code <= code;
                    track_mode <= 1'b0;
                end
            end else if (boot_load) begin
                vout1_code <= BOOT_CODES[CODE_W*int'(boot_sel) +: CODE_W];
                track_mode <= 1'b1;
            end
        end
    end

    p_both_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit && cmd == CMD_BOTH |=> vout1_code == $past(code) && track_mode);
    p_out2_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit && cmd == CMD_OUT2 |=>
            vout2_code == $past(code) && !track_mode && $stable(vout1_code));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit && !boot_load |=>
            $stable(vout1_code) && $stable(vout2_code) && $stable(track_mode));
    p_boot_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        booted && !commit |=> $stable(vout1_code));
    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        written && !commit |=> $stable(vout1_code));
endmodule

// File: rtl/svid_rx.sv
module svid_rx
    import svid_pkg::*;
#(
    parameter int                  SYNC_STAGES = 2,
    parameter logic [4*CODE_W-1:0] BOOT_CODES  = {7'h18, 7'h20, 7'h28, 7'h30}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic [1:0]        strap,
    input  logic [1:0]        boot_sel,
    input  logic              enable,
    output logic [CODE_W-1:0] vout1_code,
    output logic [CODE_W-1:0] vout2_code,
    output logic              track_mode
);
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic commit;
    cmd_e cmd;
    logic [CODE_W-1:0] code;

    svid_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    svid_byte_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .strap(strap), .sda_pull(sda_pull), .commit(commit), .cmd(cmd),
        .code(code)
    );

    svid_regs #(.BOOT_CODES(BOOT_CODES)) u_regs (
        .clk(clk), .rst_n(rst_n), .commit(commit), .cmd(cmd), .code(code),
        .enable(enable), .boot_sel(boot_sel), .vout1_code(vout1_code),
        .vout2_code(vout2_code), .track_mode(track_mode)
    );
endmodule

// File: tb/svid_rx_bench.sv
module svid_rx_bench;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic host_sda = 1'b1;
    logic sda_pull;
    logic [1:0] strap = 2'b11;
    logic [1:0] boot_sel = 2'b00;
    logic enable = 1'b0;
    logic [6:0] vout1_code, vout2_code;
    logic track_mode;
    wire sda_bus = host_sda & ~sda_pull;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    svid_rx u_svid_rx (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_bus),
        .sda_pull(sda_pull), .strap(strap), .boot_sel(boot_sel),
        .enable(enable), .vout1_code(vout1_code), .vout2_code(vout2_code),
        .track_mode(track_mode)
    );

    // expected state
    logic [6:0] e_v1, e_v2;
    logic       e_tr;

    function automatic int dec(input logic [7:0] b, input logic [1:0] id);
        if (b[7:5] != 3'b110 || b[4] != id[1] || b[3] != id[0] || b[0]) return 0;
        if (b[2:1] == 2'b10) return 1;
        if (b[2:1] == 2'b01) return 2;
        return 0;
    endfunction

    function automatic logic [6:0] boot_code(input logic [1:0] s);
        return 7'h30 - 7'(8 * int'(s));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_regs(input string req);
        chk({req, " vout1"}, vout1_code, e_v1);
        chk({req, " vout2"}, vout2_code, e_v2);
        chk({req, " track"}, track_mode, e_tr);
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        host_sda = 1'b1; wq();
        scl_drv = 1'b1; wq();
        host_sda = 1'b0; wq();
        scl_drv = 1'b0; wq();
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; wq();
        scl_drv = 1'b1; wq();
        host_sda = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            host_sda = b[i]; wq();
            scl_drv = 1'b1; wq(); wq();
            scl_drv = 1'b0; wq();
        end
        host_sda = 1'b1; wq();
        scl_drv = 1'b1; wq();
        acked = ~sda_bus;
        wq();
        scl_drv = 1'b0; wq();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        e_v1 = '0; e_v2 = '0; e_tr = 1'b1;
    endtask

    // One transfer with the model; abort = end in repeated start + stop
    task automatic xfer(input logic [7:0] a, input int nd,
                        input logic [7:0] d0, input logic [7:0] d1,
                        input bit abort, input string req);
        logic ack;
        int c;
        c = dec(a, strap);
        bus_start();
        send_byte(a, ack);
        chk({req, " R3 addr ack"}, ack, c != 0);
        if (nd >= 1) begin
            send_byte(d0, ack);
            chk({req, " R3 data ack"}, ack, c != 0);
        end
        if (nd >= 2) begin
            send_byte(d1, ack);
            chk({req, " R3 data ack"}, ack, c != 0);
        end
        if (abort) bus_start();
        bus_stop();
        wq();
        if (!abort && nd >= 1 && c != 0) begin
            logic [7:0] last;
            last = (nd >= 2) ? d1 : d0;
            if (c == 1) begin e_v1 = last[6:0]; e_tr = 1'b1; end
            else begin e_v2 = last[6:0]; e_tr = 1'b0; end
        end
        chk_regs(req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'h5eed_1234);
        do_reset();
        // R10 reset state
        chk_regs("R10 reset");
        chk("R10 sda released", sda_pull, 0);

        // R8 boot on first enable edge
        boot_sel = 2'd2;
        @(negedge clk); enable = 1'b1;
        repeat (4) @(negedge clk);
        e_v1 = boot_code(2'd2); e_tr = 1'b1;
        chk_regs("R8 boot load");
        boot_sel = 2'd0; enable = 1'b0;
        repeat (3) @(negedge clk); enable = 1'b1;
        repeat (4) @(negedge clk);
        chk_regs("R8 second edge ignored");

        // R8 other selector values
        for (int s = 0; s < 4; s++) begin
            enable = 1'b0;
            do_reset();
            boot_sel = 2'(s);
            @(negedge clk); enable = 1'b1;
            repeat (4) @(negedge clk);
            e_v1 = boot_code(2'(s)); e_tr = 1'b1;
            chk_regs("R8 boot sel");
        end

        // R9 serial write before enable wins
        enable = 1'b0;
        do_reset();
        strap = 2'b11;
        xfer(8'hDC, 1, 8'h55, 8'h00, 0, "R9 R5 early write");
        boot_sel = 2'd1;
        @(negedge clk); enable = 1'b1;
        repeat (4) @(negedge clk);
        chk_regs("R9 boot suppressed");

        // directed corners
        xfer(8'hDC, 1, 8'hC4, 8'h00, 0, "R4 R5 psi bit dropped");
        xfer(8'hDA, 1, 8'h9B, 8'h00, 0, "R4 R6 out2 margin");
        xfer(8'hDC, 0, 8'h00, 8'h00, 0, "R7 address only");
        xfer(8'hDC, 1, 8'h11, 8'h00, 1, "R7 repeated start abort");
        xfer(8'hDA, 2, 8'h21, 8'h42, 0, "R7 last byte wins");
        xfer(8'hDD, 1, 8'h33, 8'h00, 0, "R2 R3 read ignored");
        xfer(8'hDE, 1, 8'h33, 8'h00, 0, "R2 bad low bits");
        strap = 2'b01;
        xfer(8'hDC, 1, 8'h44, 8'h00, 0, "R2 strap mismatch");
        xfer(8'hCC, 1, 8'h46, 8'h00, 0, "R2 R5 strap 01 both");

        // constrained random
        for (int it = 0; it < 40; it++) begin
            logic [7:0] a;
            int kind;
            strap = 2'($urandom_range(0, 3));
            kind = $urandom_range(0, 4);
            unique case (kind)
                0: a = {3'b110, strap, 2'b10, 1'b0};
                1: a = {3'b110, strap, 2'b01, 1'b0};
                2: a = {3'b110, strap, 2'($urandom_range(0, 3)), 1'b1};
                3: a = {3'b110, ~strap, 2'b10, 1'b0};
                default: a = 8'($urandom);
            endcase
            xfer(a, $urandom_range(0, 2), 8'($urandom), 8'($urandom),
                 ($urandom_range(0, 5) == 0), "R1 R2 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule